// File: doc/BRIEF.md
# Same-Address Collision Arbiter with Write Inhibit

This block sits between two independent access ports and a shared dual-port memory array. On every clock it compares the two ports' enables and addresses. When both ports select the same word, one port is allowed to continue and the other is told it is busy. The busy port's write strobe is also blocked before it reaches the array. The decision looks only at enable and address, so a read collides exactly as a write does.

A mode input picks one of two roles. In master mode the block arbitrates and drives two active-low busy outputs. It also emits a one-cycle collision pulse that can be wired to an error interrupt. In slave mode the block does no arbitration. It takes the two active-low busy inputs, normally driven by a master placed alongside it for width expansion, and uses each one only to inhibit writes on its own port. This way every slice of a wide word obeys the same decision.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode a busy output is driven low only in a cycle where both enables are high with equal addresses, or in the cycle right after such a cycle.
- R2: At most one of the two busy outputs is low in any cycle.
- R3: When both ports start a matching access in the same cycle, with neither port enabled on that address in the cycle before, the left port wins and `r_busy_out_n` goes low in that same cycle.
- R4: When one port was already enabled on an address in the previous cycle and the other port arrives on it, the port already there wins and the arriving port gets busy.
- R5: A write strobe from a port whose busy is low (its output in master mode, its input in slave mode) never reaches the array. This includes a write issued in the very cycle in which the collision first appears.
- R6: The write strobes have no effect on the busy decision. A collision of two reads gives the same busy outputs as a collision of two writes.
- R7: Busy stays low through the cycle in which the match ends, whether the winner deselects or changes address. It returns high in the following cycle.
- R8: In master mode `collision` is high for exactly one cycle, in the first cycle of each busy episode, and stays low while that busy is held.
- R9: In slave mode (`master_mode`=0) both busy outputs stay high and `collision` stays low. Each port's array write equals enable AND write AND its busy input, so a high input gives normal writes and a low input blocks every write on that port.
- R10: A port that is enabled and not busy passes its write strobe to the array in the same cycle.
- R11: While `rst_n` is low, both array writes are low, both busy outputs are high and `collision` is low. After reset, no port counts as already holding an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = use busy inputs as write inhibits |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port word address |
| l_we | input | 1 | Left port write strobe |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port word address |
| r_we | input | 1 | Right port write strobe |
| l_busy_in_n | input | 1 | Left write inhibit from an external master, active low (slave mode) |
| r_busy_in_n | input | 1 | Right write inhibit from an external master, active low (slave mode) |
| l_busy_out_n | output | 1 | Left busy indication, active low (master mode) |
| r_busy_out_n | output | 1 | Right busy indication, active low (master mode) |
| l_we_mem | output | 1 | Gated left write enable to the array |
| r_we_mem | output | 1 | Gated right write enable to the array |
| collision | output | 1 | One-cycle pulse at the start of each busy episode (master mode) |

## Verification
The bound checker watches on every cycle that busy never appears without a current or just-ended address match, and that the two busy lines are never low together. It also checks that a busy port's write never reaches the array, that the collision pulse never lasts two cycles, and that slave mode keeps the outputs quiet. Only the directed scenarios can show who wins, which needs knowledge of the previous cycle. The same holds for the one-cycle hold after a match ends, the equal treatment of reads and writes, and the forcing of writes by the slave inhibit inputs.

// File: rtl/dpca_pkg.sv
// Package: shared types for the same-address collision arbiter.
// Assumes exactly two ports, called left and right.
package dpca_pkg;
    // Which port held the contested address in the last cycle.
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;
endpackage

// File: rtl/dpca_port_track.sv
// Module: remembers one port's enable and address from the previous cycle.
// It reports whether the port is continuing an access it already held
// on the same address. Assumes a synchronous active-low reset.
module dpca_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              cont
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the port's selection for comparison in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // The port continues when it was and still is on the same word.
    always_comb begin
        cont = en && en_q && (addr_q == addr);
    end
endmodule

// File: rtl/dpca_decide.sv
// Module: the collision decision. It detects a same-address selection,
// picks the winner (the current holder, then a continuing port, else left),
// keeps the loser busy for one cycle after the match ends, and flags
// the first cycle of each busy episode. Assumes a synchronous active-low reset.
module dpca_decide
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_cont,
    input  logic              r_cont,
    output logic              l_busy,
    output logic              r_busy,
    output logic              onset
);
    holder_e holder_q;
    holder_e holder_d;
    logic    match;
    logic    any_busy;
    logic    any_busy_q;

    // Same-word selection by both ports; the read or write kind is not used.
    always_comb begin
        match = l_en && r_en && (l_addr == r_addr);
    end

    // Choose the winner for this cycle.
    always_comb begin
        holder_d = HOLD_NONE;
        if (match) begin
            if (holder_q != HOLD_NONE)
                holder_d = holder_q;
            else if (r_cont && !l_cont)
                holder_d = HOLD_RIGHT;
            else
                holder_d = HOLD_LEFT;
        end
    end

    // The loser is busy during the match and for one cycle after it.
    always_comb begin
        l_busy   = (holder_d == HOLD_RIGHT) || (holder_q == HOLD_RIGHT);
        r_busy   = (holder_d == HOLD_LEFT)  || (holder_q == HOLD_LEFT);
        any_busy = l_busy || r_busy;
        onset    = any_busy && !any_busy_q;
    end

    // Record the winner and the busy state for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder_q   <= HOLD_NONE;
            any_busy_q <= 1'b0;
        end else begin
            holder_q   <= holder_d;
            any_busy_q <= any_busy;
        end
    end
endmodule

// File: rtl/dpca_wgate.sv
// Module: blocks one port's write strobe while its inhibit is active.
// Writes are also held off during reset. The inhibit input is active low.
module dpca_wgate (
    input  logic rst_n,
    input  logic en,
    input  logic we,
    input  logic inhibit_n,
    output logic we_mem
);
    // Pass the strobe only for a selected, uninhibited port out of reset.
    always_comb begin
        we_mem = rst_n && en && we && inhibit_n;
    end
endmodule

// File: rtl/dp_collision_arbiter.sv
// Module: top of the same-address collision arbiter. In master mode it
// arbitrates and drives the active-low busy outputs. In slave mode it uses
// the busy inputs as per-port write inhibits. The memory array is outside.
module dp_collision_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_out_n,
    output logic              r_busy_out_n,
    output logic              l_we_mem,
    output logic              r_we_mem,
    output logic              collision
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]             en_v;
    logic [NPORT-1:0]             we_v;
    logic [NPORT-1:0]             cont_v;
    logic [NPORT-1:0]             inh_n_v;
    logic [NPORT-1:0]             wmem_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic                         l_busy;
    logic                         r_busy;
    logic                         onset;

    // Gather the per-port signals into vectors (index 0 = left).
    always_comb begin
        en_v   = {r_en, l_en};
        we_v   = {r_we, l_we};
        addr_v = {r_addr, l_addr};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_track
        dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .cont  (cont_v[p])
        );
    end

    dpca_decide #(.ADDR_W(ADDR_W)) u_decide (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (l_en),
        .r_en   (r_en),
        .l_addr (l_addr),
        .r_addr (r_addr),
        .l_cont (cont_v[0]),
        .r_cont (cont_v[1]),
        .l_busy (l_busy),
        .r_busy (r_busy),
        .onset  (onset)
    );

    // Pick the inhibit source by mode and drive the busy outputs.
    always_comb begin
        if (master_mode) begin
            inh_n_v = {~r_busy, ~l_busy};
        end else begin
            inh_n_v = {r_busy_in_n, l_busy_in_n};
        end
        l_busy_out_n = !(rst_n && master_mode && l_busy);
        r_busy_out_n = !(rst_n && master_mode && r_busy);
        collision    = rst_n && master_mode && onset;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_gate
        dpca_wgate u_gate (
            .rst_n     (rst_n),
            .en        (en_v[p]),
            .we        (we_v[p]),
            .inhibit_n (inh_n_v[p]),
            .we_mem    (wmem_v[p])
        );
    end

    // Hand the gated strobes to the array.
    always_comb begin
        l_we_mem = wmem_v[0];
        r_we_mem = wmem_v[1];
    end
endmodule

// File: rtl/dpca_checker.sv
// Module: property checker for dp_collision_arbiter, bound to every instance.
// It looks only at the top-level ports.
module dpca_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_out_n,
    input logic              r_busy_out_n,
    input logic              l_we_mem,
    input logic              r_we_mem,
    input logic              collision
);
    logic same_word;
    assign same_word = l_en && r_en && (l_addr == r_addr);

    // R1
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_out_n || !r_busy_out_n) |-> (same_word || $past(same_word)));

    // R2
    single_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!l_busy_out_n, !r_busy_out_n}));

    // R5
    l_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((master_mode && !l_busy_out_n) || (!master_mode && !l_busy_in_n)) |-> !l_we_mem);

    // R5
    r_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((master_mode && !r_busy_out_n) || (!master_mode && !r_busy_in_n)) |-> !r_we_mem);

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision);

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_out_n && r_busy_out_n && !collision));
endmodule

bind dp_collision_arbiter dpca_checker #(.ADDR_W(ADDR_W)) u_dpca_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_mode  (master_mode),
    .l_en         (l_en),
    .l_addr       (l_addr),
    .r_en         (r_en),
    .r_addr       (r_addr),
    .l_busy_in_n  (l_busy_in_n),
    .r_busy_in_n  (r_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .r_busy_out_n (r_busy_out_n),
    .l_we_mem     (l_we_mem),
    .r_we_mem     (r_we_mem),
    .collision    (collision)
);

// File: tb/dp_collision_arbiter_bench.sv
// Directed bench: one task per scenario. Inputs change on the falling edge
// and outputs are sampled 1 ns later, well before the next rising edge.
module dp_collision_arbiter_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_en = 1'b0, r_en = 1'b0, l_we = 1'b0, r_we = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_out_n, r_busy_out_n, l_we_mem, r_we_mem, collision;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dp_collision_arbiter #(.ADDR_W(AW)) u_dp_collision_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_we(l_we),
        .r_en(r_en), .r_addr(r_addr), .r_we(r_we),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
        .l_we_mem(l_we_mem), .r_we_mem(r_we_mem), .collision(collision)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus on the falling edge, then settle.
    task automatic drive(input logic le, input logic [AW-1:0] la, input logic lw,
                         input logic re, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        l_en = le; l_addr = la; l_we = lw;
        r_en = re; r_addr = ra; r_we = rw;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        l_en = 1'b1; r_en = 1'b1; l_we = 1'b1; r_we = 1'b1;
        l_addr = 11'h7FE; r_addr = 11'h7FE;
        @(negedge clk); #1;
        chk("R11", "l_we_mem in reset", l_we_mem, 1'b0);
        chk("R11", "r_we_mem in reset", r_we_mem, 1'b0);
        chk("R11", "l_busy_out_n in reset", l_busy_out_n, 1'b1);
        chk("R11", "r_busy_out_n in reset", r_busy_out_n, 1'b1);
        chk("R11", "collision in reset", collision, 1'b0);
        idle();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_no_clash();
        drive(1'b1, 11'h010, 1'b1, 1'b1, 11'h011, 1'b1);
        chk("R1", "busy L different addr", l_busy_out_n, 1'b1);
        chk("R1", "busy R different addr", r_busy_out_n, 1'b1);
        chk("R10", "l write passes", l_we_mem, 1'b1);
        chk("R10", "r write passes", r_we_mem, 1'b1);
        idle();
    endtask

    task automatic t_fresh_clash(input logic wr);
        drive(1'b1, 11'h123, wr, 1'b1, 11'h123, wr);
        chk("R3", "right busy on fresh match", r_busy_out_n, 1'b0);
        chk("R3", "left free on fresh match", l_busy_out_n, 1'b1);
        chk("R6", "busy same for read/write", r_busy_out_n, 1'b0);
        chk("R8", "collision first cycle", collision, 1'b1);
        chk("R5", "right write blocked same cycle", r_we_mem, 1'b0);
        chk("R10", "left winner write", l_we_mem, wr);
        drive(1'b1, 11'h123, 1'b1, 1'b1, 11'h123, 1'b1);
        chk("R8", "collision not repeated", collision, 1'b0);
        chk("R5", "right write still blocked", r_we_mem, 1'b0);
        // Winner changes address: busy held this cycle, free next cycle.
        drive(1'b1, 11'h124, 1'b0, 1'b1, 11'h123, 1'b1);
        chk("R7", "busy held in end cycle", r_busy_out_n, 1'b0);
        chk("R7", "write blocked in end cycle", r_we_mem, 1'b0);
        drive(1'b1, 11'h124, 1'b0, 1'b1, 11'h123, 1'b1);
        chk("R7", "busy released", r_busy_out_n, 1'b1);
        chk("R7", "write freed", r_we_mem, 1'b1);
        idle();
    endtask

    task automatic t_incumbent();
        drive(1'b0, 11'h055, 1'b0, 1'b1, 11'h055, 1'b0);
        chk("R4", "no busy alone", l_busy_out_n, 1'b1);
        drive(1'b1, 11'h055, 1'b1, 1'b1, 11'h055, 1'b1);
        chk("R4", "arriving left busy", l_busy_out_n, 1'b0);
        chk("R4", "holding right free", r_busy_out_n, 1'b1);
        chk("R5", "left write blocked", l_we_mem, 1'b0);
        chk("R10", "right write passes", r_we_mem, 1'b1);
        drive(1'b1, 11'h055, 1'b0, 1'b0, 11'h055, 1'b0);
        chk("R7", "left busy held after right leaves", l_busy_out_n, 1'b0);
        idle();
        chk("R7", "left busy released", l_busy_out_n, 1'b1);
        idle();
    endtask

    task automatic t_slave();
        master_mode = 1'b0;
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        drive(1'b1, 11'h200, 1'b1, 1'b1, 11'h200, 1'b1);
        chk("R9", "slave busy L high", l_busy_out_n, 1'b1);
        chk("R9", "slave busy R high", r_busy_out_n, 1'b1);
        chk("R9", "slave no collision", collision, 1'b0);
        chk("R9", "slave l write normal", l_we_mem, 1'b1);
        chk("R9", "slave r write normal", r_we_mem, 1'b1);
        l_busy_in_n = 1'b0;
        drive(1'b1, 11'h300, 1'b1, 1'b1, 11'h301, 1'b1);
        chk("R9", "slave l inhibited", l_we_mem, 1'b0);
        chk("R9", "slave r unaffected", r_we_mem, 1'b1);
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
        drive(1'b1, 11'h300, 1'b1, 1'b1, 11'h301, 1'b1);
        chk("R9", "slave r inhibited", r_we_mem, 1'b0);
        chk("R9", "slave l normal again", l_we_mem, 1'b1);
        r_busy_in_n = 1'b1;
        idle();
        master_mode = 1'b1;
        idle();
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        idle();
        t_no_clash();
        t_fresh_clash(1'b0);
        idle();
        t_fresh_clash(1'b1);
        idle();
        t_incumbent();
        t_slave();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule